// File: doc/BRIEF.md
# Disk Sequencer Host Register Bridge

This block sits between a host processor's control bus and a microprogrammed disk sequencer. The host first selects a target with a 4-bit select value and then strobes a 16-bit word in or out. Writes to the disk-access select are sorted by their top nibble. One nibble value loads a cylinder number and another loads a command word. A command write also raises the incoming "B" request toward the host. A write to the reset select arms a panic-reset flag. The sequencer retires that flag on its next rising clock, and the B request is withdrawn at the same moment.

Reads return an assembled 8-bit status byte or one of two configuration-switch words; every other select reads as zero. A separate system-control word holds two host-writable enables. It also reflects the live request levels. Two interrupt lines are asserted only while a request and its enable are both set. The block also produces the sequencer clock, which toggles once per incoming tick enable.

Top module: `dsc_host_bridge`

## Requirements
- R1: A control write with select 1 and top nibble (bits 15:12) equal to 0 loads wrData[9:0] into cylNum one cycle later; cmdWord is unchanged.
- R2: A control write with select 1 and top nibble 2 loads wrData[11:0] into cmdWord and sets the B request (sysCtrlWord bit 15) one cycle later; cylNum is unchanged.
- R3: A control write with select 1 and any other top nibble, or with any select other than 1 and 15, leaves cylNum, cmdWord, the B request and panicRst unchanged.
- R4: A control write with select 15 sets panicRst one cycle later. The first clock cycle whose tick makes seqClk rise clears panicRst and the B request at the same edge.
- R5: While ctlRdStb is high, rdData shows the status byte in bits 7:0 (upper bits zero) for select 15, cfgSwA for select 12, cfgSwB for select 14, and zero for every other select. While ctlRdStb is low, rdData is zero.
- R6: The status byte holds microStat in bits 2:0, drvReady in bit 3, drvWrProt in bit 4, edCount in bits 6:5 and drvFault in bit 7.
- R7: A system-control write changes only the A enable (from wrData bit 6) and the B enable (from wrData bit 5). sysCtrlWord shows the A enable in bit 6, the B enable in bit 5, the A request in bit 7 (reqAIn registered once) and the B request in bit 15, with all other bits zero.
- R8: irqA is high exactly while the A request and the A enable are both set. irqB is high exactly while the B request and the B enable are both set.
- R9: seqClk inverts on each clock edge that samples tickStb high and holds otherwise, so one full sequencer period takes two ticks.
- R10: After reset, cylNum, cmdWord, panicRst, seqClk, both enables, both requests, irqA and irqB are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickStb | input | 1 | Sequencer tick enable; each high cycle toggles seqClk |
| selVal | input | 4 | Control-bus select value |
| wrData | input | 16 | Host write data |
| ctlWrStb | input | 1 | Control-bus write strobe |
| ctlRdStb | input | 1 | Control-bus read strobe |
| sysWrStb | input | 1 | System-control write strobe |
| microStat | input | 3 | Status bits from the current microword |
| drvReady | input | 1 | Drive ready status |
| drvWrProt | input | 1 | Drive write-protect status |
| drvFault | input | 1 | Drive fault status |
| edCount | input | 2 | Low two bits of the sequencer's ED counter |
| cfgSwA | input | 16 | Configuration-switch word read at select 12 |
| cfgSwB | input | 16 | Configuration-switch word read at select 14 |
| reqAIn | input | 1 | Incoming A request level |
| cylNum | output | 10 | Latched cylinder number |
| cmdWord | output | 12 | Latched command word |
| panicRst | output | 1 | Panic-reset flag toward the sequencer |
| seqClk | output | 1 | Generated sequencer clock |
| rdData | output | 16 | Control-bus read data |
| sysCtrlWord | output | 16 | System-control word: enables and request levels |
| irqA | output | 1 | Interrupt for request A |
| irqB | output | 1 | Interrupt for request B |

## Verification
Assertions check several rules on every cycle. Registers change only in a cycle after their own decoded strobe, an enable changes only after a system-control write, a command load leaves the B request set, an armed panic flag clears on a rising sequencer clock, seqClk follows the tick, and an interrupt rises only after a command load or an enable write. Other behaviour shows only in the bench's sweeps. These cover the exact nibble and select decode over all 256 select/nibble pairs, the bit layout of the status byte over all field values, the read multiplexer for every select, and all sixteen combinations of enables and request levels against the interrupt lines.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  // Strobes the control half hands to the datapath half, one cycle each.
  typedef struct packed {
    logic cylLoad;   // load cylinder register
    logic cmdLoad;   // load command register, raise B request
    logic panicSet;  // arm panic flag
    logic reqBDrop;  // panic retired: drop B request
    logic enLoad;    // system-control write of enables
  } dscStrb_t;
endpackage

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
  import dsc_pkg::*;
#(
  parameter int SEL_W     = 4,
  parameter int NIB_W     = 4,
  parameter int SEL_DISK  = 1,
  parameter int SEL_PANIC = 15,
  parameter int NIB_CYL   = 0,
  parameter int NIB_CMD   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickStb,
  input  logic [SEL_W-1:0] selVal,
  input  logic [NIB_W-1:0] topNib,
  input  logic             ctlWrStb,
  input  logic             sysWrStb,
  output dscStrb_t         strb,
  output logic             panicRst,
  output logic             seqClk
);
  localparam logic [SEL_W-1:0] SelDisk  = SEL_W'(SEL_DISK);
  localparam logic [SEL_W-1:0] SelPanic = SEL_W'(SEL_PANIC);
  localparam logic [NIB_W-1:0] NibCyl   = NIB_W'(NIB_CYL);
  localparam logic [NIB_W-1:0] NibCmd   = NIB_W'(NIB_CMD);

  logic seqClkQ;
  logic panicQ;
  logic seqRise;
  logic diskWr;

  assign diskWr  = ctlWrStb && (selVal == SelDisk);
  assign seqRise = tickStb && !seqClkQ;

  always_comb begin
    strb          = '0;
    strb.cylLoad  = diskWr && (topNib == NibCyl);
    strb.cmdLoad  = diskWr && (topNib == NibCmd);
    strb.panicSet = ctlWrStb && (selVal == SelPanic);
    strb.reqBDrop = panicQ && seqRise && !strb.panicSet;
    strb.enLoad   = sysWrStb;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seqClkQ <= 1'b0;
    end else if (tickStb) begin
      seqClkQ <= !seqClkQ;
    end
  end

  // New arming wins over retirement in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      panicQ <= 1'b0;
    end else if (strb.panicSet) begin
      panicQ <= 1'b1;
    end else if (seqRise) begin
      panicQ <= 1'b0;
    end
  end

  assign panicRst = panicQ;
  assign seqClk   = seqClkQ;

  p_seqclk_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tickStb |=> (seqClkQ != $past(seqClkQ)));
  p_seqclk_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tickStb |=> $stable(seqClkQ));
  p_panic_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (panicQ && tickStb && !seqClkQ && !(ctlWrStb && selVal == SelPanic)) |=> !panicQ);
  p_panic_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlWrStb && selVal == SelPanic) |=> panicQ);
endmodule

// File: rtl/dsc_dpath.sv
module dsc_dpath
  import dsc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SEL_W     = 4,
  parameter int CYL_W     = 10,
  parameter int CMD_W     = 12,
  parameter int MSTAT_W   = 3,
  parameter int ED_W      = 2,
  parameter int SEL_STAT  = 15,
  parameter int SEL_CFG_A = 12,
  parameter int SEL_CFG_B = 14,
  parameter int REQA_BIT  = 7,
  parameter int REQB_BIT  = 15,
  parameter int ENA_BIT   = 6,
  parameter int ENB_BIT   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dscStrb_t           strb,
  input  logic [CMD_W-1:0]   cmdSrc,
  input  logic               enSrcA,
  input  logic               enSrcB,
  input  logic               ctlRdStb,
  input  logic [SEL_W-1:0]   selVal,
  input  logic [MSTAT_W-1:0] microStat,
  input  logic               drvReady,
  input  logic               drvWrProt,
  input  logic               drvFault,
  input  logic [ED_W-1:0]    edCount,
  input  logic [DATA_W-1:0]  cfgSwA,
  input  logic [DATA_W-1:0]  cfgSwB,
  input  logic               reqAIn,
  output logic [CYL_W-1:0]   cylNum,
  output logic [CMD_W-1:0]   cmdWord,
  output logic [DATA_W-1:0]  rdData,
  output logic [DATA_W-1:0]  sysCtrlWord,
  output logic               irqA,
  output logic               irqB
);
  localparam int STAT_W = MSTAT_W + 3 + ED_W;
  localparam logic [SEL_W-1:0] SelStat = SEL_W'(SEL_STAT);
  localparam logic [SEL_W-1:0] SelCfgA = SEL_W'(SEL_CFG_A);
  localparam logic [SEL_W-1:0] SelCfgB = SEL_W'(SEL_CFG_B);

  logic [CYL_W-1:0] cylQ;
  logic [CMD_W-1:0] cmdQ;
  logic             reqAQ, reqBQ, enAQ, enBQ;
  logic [STAT_W-1:0] statByte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cylQ <= '0;
      cmdQ <= '0;
    end else begin
      if (strb.cylLoad) cylQ <= cmdSrc[CYL_W-1:0];
      if (strb.cmdLoad) cmdQ <= cmdSrc;
    end
  end

  // Command load wins over a panic-driven drop in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqBQ <= 1'b0;
    end else if (strb.cmdLoad) begin
      reqBQ <= 1'b1;
    end else if (strb.reqBDrop) begin
      reqBQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqAQ <= 1'b0;
      enAQ  <= 1'b0;
      enBQ  <= 1'b0;
    end else begin
      reqAQ <= reqAIn;
      if (strb.enLoad) begin
        enAQ <= enSrcA;
        enBQ <= enSrcB;
      end
    end
  end

  // Status byte: fault, ED count, write protect, ready, microword bits (MSB first).
  assign statByte = {drvFault, edCount, drvWrProt, drvReady, microStat};

  always_comb begin
    rdData = '0;
    if (ctlRdStb) begin
      unique case (selVal)
        SelStat: rdData = DATA_W'(statByte);
        SelCfgA: rdData = cfgSwA;
        SelCfgB: rdData = cfgSwB;
        default: rdData = '0;
      endcase
    end
  end

  always_comb begin
    sysCtrlWord           = '0;
    sysCtrlWord[REQA_BIT] = reqAQ;
    sysCtrlWord[REQB_BIT] = reqBQ;
    sysCtrlWord[ENA_BIT]  = enAQ;
    sysCtrlWord[ENB_BIT]  = enBQ;
  end

  assign irqA    = reqAQ && enAQ;
  assign irqB    = reqBQ && enBQ;
  assign cylNum  = cylQ;
  assign cmdWord = cmdQ;

  p_cyl_only_on_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cylQ) |-> $past(strb.cylLoad));
  p_cmd_only_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmdQ) |-> $past(strb.cmdLoad));
  p_cmd_raises_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.cmdLoad |=> reqBQ);
  p_enable_only_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(enAQ) || !$stable(enBQ)) |-> $past(strb.enLoad));
  p_irqb_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqB) |-> $past(strb.cmdLoad || strb.enLoad));
  p_reqb_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reqBQ) |-> $past(strb.reqBDrop));
endmodule

// File: rtl/dsc_host_bridge.sv
module dsc_host_bridge
  import dsc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 4,
  parameter int CYL_W  = 10,
  parameter int CMD_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickStb,
  input  logic [SEL_W-1:0]  selVal,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ctlWrStb,
  input  logic              ctlRdStb,
  input  logic              sysWrStb,
  input  logic [2:0]        microStat,
  input  logic              drvReady,
  input  logic              drvWrProt,
  input  logic              drvFault,
  input  logic [1:0]        edCount,
  input  logic [DATA_W-1:0] cfgSwA,
  input  logic [DATA_W-1:0] cfgSwB,
  input  logic              reqAIn,
  output logic [CYL_W-1:0]  cylNum,
  output logic [CMD_W-1:0]  cmdWord,
  output logic              panicRst,
  output logic              seqClk,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] sysCtrlWord,
  output logic              irqA,
  output logic              irqB
);
  localparam int NIB_W   = DATA_W - CMD_W;
  localparam int ENA_BIT = 6;
  localparam int ENB_BIT = 5;

  dscStrb_t strb;

  dsc_ctrl #(
    .SEL_W(SEL_W), .NIB_W(NIB_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .tickStb(tickStb), .selVal(selVal),
    .topNib(wrData[DATA_W-1 -: NIB_W]), .ctlWrStb(ctlWrStb), .sysWrStb(sysWrStb),
    .strb(strb), .panicRst(panicRst), .seqClk(seqClk)
  );

  dsc_dpath #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .CYL_W(CYL_W), .CMD_W(CMD_W),
    .ENA_BIT(ENA_BIT), .ENB_BIT(ENB_BIT)
  ) dpath_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cmdSrc(wrData[CMD_W-1:0]),
    .enSrcA(wrData[ENA_BIT]), .enSrcB(wrData[ENB_BIT]),
    .ctlRdStb(ctlRdStb), .selVal(selVal), .microStat(microStat),
    .drvReady(drvReady), .drvWrProt(drvWrProt), .drvFault(drvFault),
    .edCount(edCount), .cfgSwA(cfgSwA), .cfgSwB(cfgSwB), .reqAIn(reqAIn),
    .cylNum(cylNum), .cmdWord(cmdWord), .rdData(rdData),
    .sysCtrlWord(sysCtrlWord), .irqA(irqA), .irqB(irqB)
  );
endmodule

// File: tb/dsc_host_bridge_tb.sv
`timescale 1ns/1ps
module dsc_host_bridge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tickStb = 0, ctlWrStb = 0, ctlRdStb = 0, sysWrStb = 0;
  logic [3:0] selVal = '0;
  logic [15:0] wrData = '0;
  logic [2:0] microStat = '0;
  logic drvReady = 0, drvWrProt = 0, drvFault = 0, reqAIn = 0;
  logic [1:0] edCount = '0;
  logic [15:0] cfgSwA = 16'h1357, cfgSwB = 16'h2468;
  logic [9:0] cylNum;
  logic [11:0] cmdWord;
  logic panicRst, seqClk, irqA, irqB;
  logic [15:0] rdData, sysCtrlWord;

  int nChecks = 0, nFails = 0;
  logic [9:0] expCyl = '0;
  logic [11:0] expCmd = '0;
  logic expReqB = 0, expPanic = 0, expSeq = 0, expEnA = 0, expEnB = 0, expReqA = 0;

  always #2 clk = !clk;

  dsc_host_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .tickStb(tickStb), .selVal(selVal), .wrData(wrData),
    .ctlWrStb(ctlWrStb), .ctlRdStb(ctlRdStb), .sysWrStb(sysWrStb),
    .microStat(microStat), .drvReady(drvReady), .drvWrProt(drvWrProt),
    .drvFault(drvFault), .edCount(edCount), .cfgSwA(cfgSwA), .cfgSwB(cfgSwB),
    .reqAIn(reqAIn), .cylNum(cylNum), .cmdWord(cmdWord), .panicRst(panicRst),
    .seqClk(seqClk), .rdData(rdData), .sysCtrlWord(sysCtrlWord), .irqA(irqA), .irqB(irqB)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic checkState(input string req);
    logic [15:0] expWord;
    expWord = 16'((expReqB << 15) | (expReqA << 7) | (expEnA << 6) | (expEnB << 5));
    chk(cylNum == expCyl, {req, " cylNum"}, 32'(cylNum), 32'(expCyl));
    chk(cmdWord == expCmd, {req, " cmdWord"}, 32'(cmdWord), 32'(expCmd));
    chk(panicRst == expPanic, {req, " panicRst"}, 32'(panicRst), 32'(expPanic));
    chk(seqClk == expSeq, {req, " seqClk"}, 32'(seqClk), 32'(expSeq));
    chk(sysCtrlWord == expWord, {req, " sysCtrlWord"}, 32'(sysCtrlWord), 32'(expWord));
    chk(irqA == (expReqA & expEnA), {req, " R8 irqA"}, 32'(irqA), 32'(expReqA & expEnA));
    chk(irqB == (expReqB & expEnB), {req, " R8 irqB"}, 32'(irqB), 32'(expReqB & expEnB));
  endtask

  task automatic ctlWrite(input logic [3:0] sel, input logic [15:0] data);
    selVal = sel; wrData = data; ctlWrStb = 1;
    cyc();
    ctlWrStb = 0;
    if (sel == 4'd1 && data[15:12] == 4'd0) expCyl = data[9:0];
    if (sel == 4'd1 && data[15:12] == 4'd2) begin expCmd = data[11:0]; expReqB = 1; end
    if (sel == 4'd15) expPanic = 1;
  endtask

  task automatic tick(input bit t);
    tickStb = t;
    cyc();
    if (t) begin
      if (!expSeq && expPanic) begin expPanic = 0; expReqB = 0; end
      expSeq = !expSeq;
    end
    tickStb = 0;
  endtask

  task automatic retirePanic();
    while (expPanic) begin
      tick(1);
      checkState("R4 retire");
    end
  endtask

  initial begin
    #800000;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    checkState("R10 reset");
    cyc();
    checkState("R10 reset");

    // R9: ticks with gaps.
    for (int i = 0; i < 8; i++) begin
      tick(i % 3 != 0);
      checkState("R9 tick");
    end

    // R1 R2 R3 R4: every select / nibble pair.
    for (int s = 0; s < 16; s++) begin
      for (int n = 0; n < 16; n++) begin
        ctlWrite(4'(s), {4'(n), 12'(s * 293 + n * 71 + 5)});
        checkState("R1/R2/R3 write");
        retirePanic();
      end
    end

    // R4: panic when seqClk high needs two ticks.
    ctlWrite(4'd1, 16'h2ABC);
    if (!expSeq) tick(1);
    ctlWrite(4'd15, 16'h0000);
    checkState("R4 armed");
    tick(1);
    checkState("R4 falling tick keeps flag");
    retirePanic();

    // R5: read mux over all selects.
    microStat = 3'd5; drvReady = 1; drvFault = 0; drvWrProt = 1; edCount = 2'd2;
    for (int s = 0; s < 16; s++) begin
      logic [15:0] expRd;
      selVal = 4'(s); ctlRdStb = 1;
      #1;
      expRd = (s == 15) ? 16'(5 + 8 + 16 + 2 * 32) : (s == 12) ? cfgSwA : (s == 14) ? cfgSwB : 16'h0;
      chk(rdData == expRd, "R5 read mux", 32'(rdData), 32'(expRd));
      ctlRdStb = 0;
      #1;
      chk(rdData == 16'h0, "R5 no strobe", 32'(rdData), 32'h0);
    end

    // R6: status layout over all field values.
    selVal = 4'd15; ctlRdStb = 1;
    for (int v = 0; v < 256; v++) begin
      int expS;
      microStat = 3'(v >> 5); drvReady = v[0]; drvWrProt = v[1];
      edCount = 2'((v >> 2) & 3); drvFault = v[4];
      #1;
      expS = (v >> 5) + (v & 1) * 8 + ((v >> 1) & 1) * 16 + ((v >> 2) & 3) * 32 + ((v >> 4) & 1) * 128;
      chk(rdData == 16'(expS), "R6 status byte", 32'(rdData), 32'(expS));
    end
    ctlRdStb = 0;

    // R7 R8: enables and request levels.
    for (int m = 0; m < 16; m++) begin
      if (m[3] && !expReqB) ctlWrite(4'd1, 16'h2000 | 16'(m));
      if (!m[3] && expReqB) begin ctlWrite(4'd15, 16'h0); retirePanic(); end
      reqAIn = m[2];
      wrData = 16'hFF9F | (16'(m[0]) << 6) | (16'(m[1]) << 5);
      sysWrStb = 1;
      cyc();
      sysWrStb = 0;
      expEnA = m[0]; expEnB = m[1]; expReqA = m[2];
      checkState("R7/R8 sys");
      // A control write must not disturb the enables.
      ctlWrite(4'd1, 16'h0155);
      checkState("R7 enables kept");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule